// File: doc/BRIEF.md
# Predicated Vector Lane Execution Stage

This block is the execution stage of a small SIMD datapath. Each instruction arrives with two source vectors, the current contents of the destination vector, an opcode and the index of a predicate mask register. Every lane computes its own result, and the selected mask decides lane by lane whether that result may replace the destination element. Lanes whose predicate bit is clear hand back the old destination value with their write enable low, so the register file upstream keeps its architectural contents.

Lane-wise compares produce one condition bit per lane. These bits are gated by the active predicate and stored in a mask register, where later instructions can use them as their predicate. The stage also serves masked stores: it turns the predicate into per-byte write enables for an external memory port and passes the store data through. All outputs are registered one cycle after the input strobe, with a separate strobe for each result class.

Top module: `vlane_exec`

## Requirements
- R1: After reset, `out_valid`, `cmp_valid` and `st_valid` are 0, and mask registers 1 to 3 read as all zeros, so an operation predicated on mask 1 enables no lane.
- R2: An instruction accepted with `in_valid` high produces its strobe (`out_valid`, `cmp_valid` or `st_valid`) exactly one clock later, with its data in the same cycle.
- R3: Opcode 0 adds and opcode 1 subtracts each 32-bit lane pair modulo 2^32; a lane whose predicate bit is 1 shows the result with `out_we` bit high.
- R4: For every arithmetic opcode except select, a lane whose predicate bit is 0 returns its `in_old` element unchanged with its `out_we` bit low.
- R5: Opcode 2 (conditional move) writes the `in_a` element in lanes whose predicate bit is 1 and keeps the `in_old` element elsewhere.
- R6: Opcode 3 (conditional select) writes every lane, taking the `in_a` element where the predicate bit is 1 and the `in_b` element where it is 0; `out_we` is all ones.
- R7: Opcodes 4, 5, 6 and 7 compare a against b for equal, not equal, signed less-than and unsigned less-than; bit i of `cmp_mask` is the lane-i outcome ANDed with predicate bit i, and the same value is stored in the mask register named by `in_mdst`.
- R8: Mask register 0 always reads as all ones; a compare that names it as destination still reports `cmp_mask` but leaves it unchanged.
- R9: When a compare is predicated by the same register it writes, it is gated by the value held before the instruction, and the new value is used from the next instruction on.
- R10: Opcode 8 (masked store) raises `st_valid`, sets the four byte enables of lane i (bits 4i to 4i+3 of `st_be`) to predicate bit i, passes `in_a` to `st_data`, and raises neither `out_valid` nor `cmp_valid`.
- R11: While `in_valid` is low no strobe is raised and no mask register changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| in_op | input | 4 | Opcode (0 add, 1 sub, 2 cmov, 3 csel, 4 eq, 5 ne, 6 lt signed, 7 lt unsigned, 8 store) |
| in_msel | input | 2 | Predicate mask register index |
| in_mdst | input | 2 | Mask register written by a compare |
| in_a | input | 256 | Source vector a, lane i in bits 32i+31:32i |
| in_b | input | 256 | Source vector b |
| in_old | input | 256 | Current destination vector |
| out_valid | output | 1 | Arithmetic result strobe |
| out_data | output | 256 | Result vector |
| out_we | output | 8 | Per-lane destination write enable |
| cmp_valid | output | 1 | Compare result strobe |
| cmp_mask | output | 8 | Predicated compare outcome |
| st_valid | output | 1 | Masked store strobe |
| st_be | output | 32 | Per-byte memory write enable |
| st_data | output | 256 | Store data |

## Verification
Add and subtract run with the always-true mask and with compare-built masks, on operands that wrap in some lanes, which separates lane gating from the arithmetic itself. The four compares use signed-negative operands against zero so that signed and unsigned less-than give opposite lanes, and equality patterns with scattered matches expose any lane swap. A compare that gates its own destination register is followed by an add through that register, which tells old-mask from new-mask reads, and idle cycles with compare opcodes on the inputs show that nothing is stored without the strobe.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMOV  = 4'd2,
    OP_CSEL  = 4'd3,
    OP_CEQ   = 4'd4,
    OP_CNE   = 4'd5,
    OP_CLT   = 4'd6,
    OP_CLTU  = 4'd7,
    OP_STORE = 4'd8
  } vop_e;

endpackage

// File: rtl/vlane_dec.sv
module vlane_dec
  import vlane_pkg::*;
(
  input  logic [3:0] op,
  output logic       is_arith,
  output logic       is_cmp,
  output logic       is_store
);

  always_comb begin
    is_arith = 1'b0;
    is_cmp   = 1'b0;
    is_store = 1'b0;
    case (vop_e'(op))
      OP_ADD, OP_SUB, OP_CMOV, OP_CSEL: is_arith = 1'b1;
      OP_CEQ, OP_CNE, OP_CLT, OP_CLTU:  is_cmp   = 1'b1;
      OP_STORE:                         is_store = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/vlane_lane.sv
module vlane_lane
  import vlane_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [3:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] old,
  input  logic          pred,
  output logic [EW-1:0] res,
  output logic          we,
  output logic          cbit
);

  logic [EW-1:0] sum;
  logic [EW-1:0] diff;
  logic          raw;

  assign sum  = a + b;
  assign diff = a - b;

  always_comb begin
    res = old;
    we  = 1'b0;
    raw = 1'b0;
    case (vop_e'(op))
      OP_ADD: begin
        we  = pred;
        res = pred ? sum : old;
      end
      OP_SUB: begin
        we  = pred;
        res = pred ? diff : old;
      end
      OP_CMOV: begin
        we  = pred;
        res = pred ? a : old;
      end
      OP_CSEL: begin
        we  = 1'b1;
        res = pred ? a : b;
      end
      OP_CEQ:  raw = (a == b);
      OP_CNE:  raw = (a != b);
      OP_CLT:  raw = ($signed(a) < $signed(b));
      OP_CLTU: raw = (a < b);
      default: ;
    endcase
    cbit = raw & pred;
  end

endmodule

// File: rtl/vlane_maskfile.sv
module vlane_maskfile #(
  parameter int LANES = 8,
  parameter int NMASK = 4,
  localparam int IW   = $clog2(NMASK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    rd_idx,
  output logic [LANES-1:0] rd_mask,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [LANES-1:0] wr_mask
);

  logic [LANES-1:0] mrow [NMASK];

  for (genvar k = 0; k < NMASK; k++) begin : g_mreg
    if (k == 0) begin : g_true
      assign mrow[k] = '1;
    end else begin : g_store
      logic [LANES-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) begin
          r <= '0;
        end else if (wr_en && wr_idx == IW'(k)) begin
          r <= wr_mask;
        end
      end
      assign mrow[k] = r;
    end
  end

  assign rd_mask = mrow[rd_idx];

endmodule

// File: rtl/vlane_exec.sv
module vlane_exec #(
  parameter int LANES = 8,
  parameter int EW    = 32,
  parameter int NMASK = 4,
  localparam int W    = LANES * EW,
  localparam int BPL  = EW / 8,
  localparam int NBE  = LANES * BPL,
  localparam int IW   = $clog2(NMASK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3:0]       in_op,
  input  logic [IW-1:0]    in_msel,
  input  logic [IW-1:0]    in_mdst,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     in_old,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [LANES-1:0] out_we,
  output logic             cmp_valid,
  output logic [LANES-1:0] cmp_mask,
  output logic             st_valid,
  output logic [NBE-1:0]   st_be,
  output logic [W-1:0]     st_data
);

  logic             is_arith;
  logic             is_cmp;
  logic             is_store;
  logic [LANES-1:0] pred;
  logic [W-1:0]     lane_res;
  logic [LANES-1:0] lane_we;
  logic [LANES-1:0] lane_cbit;
  logic [NBE-1:0]   lane_be;
  logic             mwr_en;

  vlane_dec u_dec (
    .op       (in_op),
    .is_arith (is_arith),
    .is_cmp   (is_cmp),
    .is_store (is_store)
  );

  assign mwr_en = in_valid & is_cmp & (in_mdst != '0);

  vlane_maskfile #(.LANES(LANES), .NMASK(NMASK)) u_mfile (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (in_msel),
    .rd_mask (pred),
    .wr_en   (mwr_en),
    .wr_idx  (in_mdst),
    .wr_mask (lane_cbit)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vlane_lane #(.EW(EW)) u_lane (
      .op   (in_op),
      .a    (in_a[i*EW +: EW]),
      .b    (in_b[i*EW +: EW]),
      .old  (in_old[i*EW +: EW]),
      .pred (pred[i]),
      .res  (lane_res[i*EW +: EW]),
      .we   (lane_we[i]),
      .cbit (lane_cbit[i])
    );
    assign lane_be[i*BPL +: BPL] = {BPL{pred[i]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= '0;
      cmp_valid <= 1'b0;
      cmp_mask  <= '0;
      st_valid  <= 1'b0;
      st_be     <= '0;
    end else begin
      out_valid <= in_valid & is_arith;
      out_we    <= (in_valid & is_arith) ? lane_we : '0;
      cmp_valid <= in_valid & is_cmp;
      if (in_valid & is_cmp) cmp_mask <= lane_cbit;
      st_valid  <= in_valid & is_store;
      st_be     <= (in_valid & is_store) ? lane_be : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      st_data  <= '0;
    end else begin
      if (in_valid & is_arith) out_data <= lane_res;
      if (in_valid & is_store) st_data  <= in_a;
    end
  end

endmodule

// File: rtl/vlane_exec_chk.sv
module vlane_exec_chk #(
  parameter int LANES = 8,
  parameter int EW    = 32,
  parameter int NMASK = 4,
  localparam int W    = LANES * EW,
  localparam int BPL  = EW / 8,
  localparam int NBE  = LANES * BPL,
  localparam int IW   = $clog2(NMASK)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       in_op,
  input logic [IW-1:0]    in_msel,
  input logic [IW-1:0]    in_mdst,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic [W-1:0]     in_old,
  input logic             out_valid,
  input logic [W-1:0]     out_data,
  input logic [LANES-1:0] out_we,
  input logic             cmp_valid,
  input logic [LANES-1:0] cmp_mask,
  input logic             st_valid,
  input logic [NBE-1:0]   st_be,
  input logic [W-1:0]     st_data
);

  logic             valid_q;
  logic [3:0]       op_q;
  logic [IW-1:0]    msel_q;
  logic [W-1:0]     old_q;
  logic [LANES-1:0] keep_ok;
  logic [LANES-1:0] be_ok;

  always_ff @(posedge clk) begin
    valid_q <= in_valid;
    op_q    <= in_op;
    msel_q  <= in_msel;
    old_q   <= in_old;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      keep_ok[i] = out_we[i] || (out_data[i*EW +: EW] == old_q[i*EW +: EW]);
      be_ok[i]   = (st_be[i*BPL +: BPL] == '0) || (st_be[i*BPL +: BPL] == '1);
    end
  end

  // R2
  strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid || cmp_valid || st_valid) |-> valid_q);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!out_valid && !cmp_valid && !st_valid));

  // R4
  disabled_keep_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (keep_ok == '1));

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, cmp_valid, st_valid}));

  // R10
  lane_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (be_ok == '1));

  // R8
  true_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && msel_q == '0 && op_q <= 4'd2) |-> (out_we == '1));

  // R6
  select_all_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == 4'd3) |-> (out_we == '1));

endmodule

bind vlane_exec vlane_exec_chk #(.LANES(LANES), .EW(EW), .NMASK(NMASK)) u_chk (.*);

// File: tb/tb_vlane_exec.sv
module tb_vlane_exec;
  import vlane_pkg::*;

  localparam int LANES = 8;
  localparam int EW    = 32;
  localparam int W     = LANES * EW;
  localparam int NBE   = W / 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [3:0]       in_op = '0;
  logic [1:0]       in_msel = '0;
  logic [1:0]       in_mdst = '0;
  logic [W-1:0]     in_a = '0;
  logic [W-1:0]     in_b = '0;
  logic [W-1:0]     in_old = '0;
  logic             out_valid;
  logic [W-1:0]     out_data;
  logic [LANES-1:0] out_we;
  logic             cmp_valid;
  logic [LANES-1:0] cmp_mask;
  logic             st_valid;
  logic [NBE-1:0]   st_be;
  logic [W-1:0]     st_data;

  int n_checks = 0;
  int n_err    = 0;
  int cycles   = 0;
  logic [LANES-1:0] mm [4];

  vlane_exec dut (.*);

  always #5 clk = ~clk;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_sim();
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(logic [31:0] base, logic [31:0] step);
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*EW +: EW] = base + 32'(i) * step;
    return v;
  endfunction

  // lanes whose bit is set get +1, so they differ from the source
  function automatic logic [W-1:0] bump(logic [W-1:0] a, logic [7:0] bits);
    logic [W-1:0] v = a;
    for (int i = 0; i < LANES; i++)
      if (bits[i]) v[i*EW +: EW] = a[i*EW +: EW] + 32'd1;
    return v;
  endfunction

  task automatic do_op(string req, logic [3:0] op, logic [1:0] msel, logic [1:0] mdst,
                       logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] old);
    logic [LANES-1:0] p = mm[msel];
    logic [W-1:0]     er = old;
    logic [LANES-1:0] ew = '0;
    logic [LANES-1:0] ec = '0;
    logic [NBE-1:0]   ebe = '0;
    bit arith = (op <= 4'd3);
    bit cmp   = (op >= 4'd4 && op <= 4'd7);
    bit store = (op == 4'd8);
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] ea = a[i*EW +: EW];
      logic [31:0] eb = b[i*EW +: EW];
      logic raw = 1'b0;
      case (op)
        4'd0: begin ew[i] = p[i]; if (p[i]) er[i*EW +: EW] = ea + eb; end
        4'd1: begin ew[i] = p[i]; if (p[i]) er[i*EW +: EW] = ea - eb; end
        4'd2: begin ew[i] = p[i]; if (p[i]) er[i*EW +: EW] = ea; end
        4'd3: begin ew[i] = 1'b1; er[i*EW +: EW] = p[i] ? ea : eb; end
        4'd4: raw = (ea == eb);
        4'd5: raw = (ea != eb);
        4'd6: raw = ($signed(ea) < $signed(eb));
        4'd7: raw = (ea < eb);
        default: ;
      endcase
      ec[i] = raw & p[i];
      ebe[i*4 +: 4] = {4{p[i] & store}};
    end
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_msel = msel; in_mdst = mdst;
    in_a = a; in_b = b; in_old = old;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", W'(out_valid), W'(arith));
    chk(req, "cmp_valid", W'(cmp_valid), W'(cmp));
    chk(req, "st_valid", W'(st_valid), W'(store));
    if (arith) begin
      chk(req, "out_data", out_data, er);
      chk(req, "out_we", W'(out_we), W'(ew));
    end
    if (cmp) begin
      chk(req, "cmp_mask", W'(cmp_mask), W'(ec));
      if (mdst != 2'd0) mm[mdst] = ec;
    end
    if (store) begin
      chk(req, "st_be", W'(st_be), W'(ebe));
      chk(req, "st_data", st_data, a);
    end
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", W'(out_valid), '0);
    chk("R1", "cmp_valid", W'(cmp_valid), '0);
    chk("R1", "st_valid", W'(st_valid), '0);
    do_op("R1", OP_ADD, 2'd1, 2'd0, mk(1, 1), mk(2, 2), mk(32'hA0, 1));
    chk("R1", "mask1 enables nothing", W'(out_we), '0);
  endtask

  task automatic t_arith();
    do_op("R3", OP_ADD, 2'd0, 2'd0, mk(32'h7FFF_FFF0, 32'h4000_0000), mk(32'h20, 32'h1), mk(0, 0));
    do_op("R3", OP_SUB, 2'd0, 2'd0, mk(5, 1), mk(7, 3), mk(0, 0));
  endtask

  task automatic t_compare();
    logic [W-1:0] a = mk(32'hFFFF_FFFD, 1);
    do_op("R7", OP_CEQ, 2'd0, 2'd1, mk(10, 3), bump(mk(10, 3), 8'h59), mk(0, 0));
    do_op("R4", OP_ADD, 2'd1, 2'd0, mk(1, 1), mk(100, 0), mk(32'hDEAD_0000, 1));
    do_op("R7", OP_CNE, 2'd1, 2'd2, mk(4, 4), bump(mk(4, 4), 8'h0F), mk(0, 0));
    do_op("R7", OP_CLT, 2'd0, 2'd3, a, mk(0, 0), mk(0, 0));
    do_op("R7", OP_CLTU, 2'd0, 2'd3, a, mk(0, 0), mk(0, 0));
    do_op("R7", OP_CLTU, 2'd0, 2'd3, mk(0, 0), a, mk(0, 0));
    do_op("R3", OP_SUB, 2'd3, 2'd0, mk(50, 5), mk(60, 1), mk(32'h1234_0000, 16));
  endtask

  task automatic t_move_select();
    do_op("R5", OP_CMOV, 2'd1, 2'd0, mk(32'hAAAA_0000, 1), mk(0, 0), mk(32'h5555_0000, 1));
    do_op("R6", OP_CSEL, 2'd1, 2'd0, mk(32'hAAAA_0000, 1), mk(32'hBBBB_0000, 1), mk(0, 0));
  endtask

  task automatic t_self_gate();
    do_op("R9", OP_CEQ, 2'd0, 2'd2, mk(9, 1), bump(mk(9, 1), 8'h59), mk(0, 0));
    do_op("R9", OP_CNE, 2'd2, 2'd2, mk(9, 1), bump(mk(9, 1), 8'h0F), mk(0, 0));
    chk("R9", "gated by old mask", W'(cmp_mask), W'(8'h06));
    do_op("R9", OP_ADD, 2'd2, 2'd0, mk(1, 0), mk(1, 0), mk(32'hF000_0000, 1));
    chk("R9", "new mask in use", W'(out_we), W'(8'h06));
  endtask

  task automatic t_mask_zero();
    do_op("R8", OP_CEQ, 2'd0, 2'd0, mk(1, 1), bump(mk(1, 1), 8'hFF), mk(0, 0));
    do_op("R8", OP_ADD, 2'd0, 2'd0, mk(3, 3), mk(1, 0), mk(0, 0));
    chk("R8", "mask0 still all ones", W'(out_we), W'(8'hFF));
  endtask

  task automatic t_store();
    do_op("R10", OP_STORE, 2'd1, 2'd0, mk(32'hC0DE_0000, 7), mk(0, 0), mk(0, 0));
    do_op("R10", OP_STORE, 2'd0, 2'd0, mk(32'h0BAD_0000, 1), mk(0, 0), mk(0, 0));
  endtask

  task automatic t_idle();
    @(negedge clk);
    in_valid = 1'b0; in_op = OP_CEQ; in_msel = 2'd0; in_mdst = 2'd1;
    in_a = mk(0, 0); in_b = mk(0, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "no strobe", W'({out_valid, cmp_valid, st_valid}), '0);
    end
    in_op = OP_STORE;
    @(negedge clk);
    chk("R11", "no store strobe", W'(st_valid), '0);
    do_op("R11", OP_ADD, 2'd1, 2'd0, mk(2, 2), mk(2, 2), mk(32'h7777_0000, 1));
  endtask

  initial begin
    mm[0] = '1; mm[1] = '0; mm[2] = '0; mm[3] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_arith();
    t_compare();
    t_move_select();
    t_self_gate();
    t_mask_zero();
    t_store();
    t_idle();
    repeat (2) @(negedge clk);
    finish_sim();
  end

endmodule